// File: doc/BRIEF.md
# Bank Register Emulator for an 8-bit CPU

This block sits next to an 8-bit CPU that has a 16-bit address bus and no memory banking of its own. It gives the CPU two 4-bit bank registers at the two lowest addresses and drives a 4-bit bank number that extends every bus address. Register 0 holds the execution bank, which applies to ordinary cycles. Register 1 holds the indirect bank, which applies only to the data cycle of an indirect-indexed load or store. An external opcode tracker marks that cycle with `indirect_cycle`.

A write to either register is taken when phase 2 falls. A read puts the register value on the CPU data bus while phase 2 is high. Whenever the address is one of the two register locations, the bank output is forced to a reserved bank that holds no memory. External memory therefore stays off the data bus, and no copy of the register is left behind in a real bank. The reserved value is a parameter, with a default of 14.

Top module: `bankemu`

## Requirements
- R1: After synchronous reset, both registers hold bank 15, so a normal cycle at a non-register address drives bank 15.
- R2: While `addr` is 0x0000 or 0x0001, `bank` equals FORCE_BANK (default 14) in the same cycle. This holds for reads and writes and does not depend on `phi2` or `indirect_cycle`.
- R3: At any other address with `indirect_cycle` low, `bank` equals the register at address 0 (execution bank).
- R4: At any other address with `indirect_cycle` high, `bank` equals the register at address 1 (indirect bank).
- R5: A write is taken in the clock cycle where `phi2` is seen low after being high, using the `addr`, `rw` (0 = write) and `wdata` sampled on the clock before. Only `wdata[3:0]` is stored, and the new value is visible from the next cycle.
- R6: `rdata_oe` is high exactly when `phi2` is high, `rw` is 1 and `addr` is 0 or 1. During that time `rdata` is {4'b0000, register}. Address bit 0 selects the register.
- R7: Writes to any address other than 0 and 1 leave both registers unchanged.
- R8: A read access at a register address across a `phi2` fall leaves the registers unchanged.
- R9: The decode compares all 16 address bits. For example, 0x0100 and 0x8001 are neither forced nor read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| phi2 | input | 1 | CPU phase-2 level, sampled on clk |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 16 | CPU address |
| wdata | input | 8 | Data driven by the CPU |
| indirect_cycle | input | 1 | Marks the data cycle of an indirect-indexed access |
| bank | output | 4 | Bank number extending the address |
| rdata | output | 8 | Register read data toward the CPU |
| rdata_oe | output | 1 | Enable for driving rdata onto the data bus |

## Verification
The bench targets four kinds of fault. The first is an `indirect_cycle` that falls on a register address: a design that lets the indirect bank win would steer memory onto the shared bus. The second is a partial address decode: a design that ignores the upper address bits would force the bank and hijack reads at aliases such as 0x0100. The third is a write with a nonzero upper nibble: a design that stores it would return nonzero high read bits. The fourth is a read across a phase-2 fall: a design that ignores `rw` at the fall would corrupt a register. A reference model updated on every clock checks `bank`, `rdata_oe` and `rdata` each cycle.

// File: rtl/bankemu_pkg.sv
package bankemu_pkg;

    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 8;
    localparam int BANK_W   = 4;
    localparam int NUM_REGS = 2;

    typedef logic [BANK_W-1:0] bank_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef enum logic {
        SEL_EXEC = 1'b0,
        SEL_IND  = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic     hit;
        reg_sel_e sel;
    } decode_t;

    typedef struct packed {
        logic     valid;
        reg_sel_e sel;
        bank_t    nib;
    } wr_req_t;

    function automatic logic is_reg_addr(input addr_t a);
        return (a[ADDR_W-1:1] == '0);
    endfunction

endpackage

// File: rtl/bankemu_decode.sv
module bankemu_decode
    import bankemu_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    phi2,
    input  logic    rw,
    input  addr_t   addr,
    input  data_t   wdata,
    output decode_t dec,
    output wr_req_t wr
);

    logic     phi2_q;
    logic     rw_q;
    logic     hit_q;
    reg_sel_e sel_q;
    bank_t    nib_q;
    logic     unused_hi;

    assign unused_hi = ^wdata[DATA_W-1:BANK_W];

    always_comb begin
        dec.hit = is_reg_addr(addr);
        dec.sel = reg_sel_e'(addr[0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phi2_q <= 1'b0;
            rw_q   <= 1'b1;
            hit_q  <= 1'b0;
            sel_q  <= SEL_EXEC;
            nib_q  <= '0;
        end else begin
            phi2_q <= phi2;
            rw_q   <= rw;
            hit_q  <= dec.hit;
            sel_q  <= dec.sel;
            nib_q  <= wdata[BANK_W-1:0];
        end
    end

    always_comb begin
        wr.valid = phi2_q & ~phi2 & ~rw_q & hit_q;
        wr.sel   = sel_q;
        wr.nib   = nib_q;
    end

endmodule

// File: rtl/bankemu_regs.sv
module bankemu_regs
    import bankemu_pkg::*;
#(
    parameter bank_t RESET_BANK = 4'hF
) (
    input  logic    clk,
    input  logic    rst,
    input  wr_req_t wr,
    output bank_t   exec_bank,
    output bank_t   ind_bank
);

    bank_t regs [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[i] <= RESET_BANK;
            end else if (wr.valid && (int'(wr.sel) == i)) begin
                regs[i] <= wr.nib;
            end
        end
    end

    assign exec_bank = regs[int'(SEL_EXEC)];
    assign ind_bank  = regs[int'(SEL_IND)];

endmodule

// File: rtl/bankemu_mux.sv
module bankemu_mux
    import bankemu_pkg::*;
#(
    parameter bank_t FORCE_BANK = 4'hE
) (
    input  decode_t dec,
    input  logic    phi2,
    input  logic    rw,
    input  logic    indirect_cycle,
    input  bank_t   exec_bank,
    input  bank_t   ind_bank,
    output bank_t   bank,
    output data_t   rdata,
    output logic    rdata_oe
);

    bank_t rd_nib;

    always_comb begin
        if (dec.hit) begin
            bank = FORCE_BANK;
        end else if (indirect_cycle) begin
            bank = ind_bank;
        end else begin
            bank = exec_bank;
        end
    end

    assign rd_nib   = (dec.sel == SEL_IND) ? ind_bank : exec_bank;
    assign rdata    = {{(DATA_W-BANK_W){1'b0}}, rd_nib};
    assign rdata_oe = dec.hit & phi2 & rw;

endmodule

// File: rtl/bankemu.sv
module bankemu
    import bankemu_pkg::*;
#(
    parameter logic [3:0] FORCE_BANK = 4'hE,
    parameter logic [3:0] RESET_BANK = 4'hF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        phi2,
    input  logic        rw,
    input  logic [15:0] addr,
    input  logic [7:0]  wdata,
    input  logic        indirect_cycle,
    output logic [3:0]  bank,
    output logic [7:0]  rdata,
    output logic        rdata_oe
);

    decode_t dec;
    wr_req_t wr_req;
    bank_t   exec_bank;
    bank_t   ind_bank;

    bankemu_decode u_decode (
        .clk   (clk),
        .rst   (rst),
        .phi2  (phi2),
        .rw    (rw),
        .addr  (addr),
        .wdata (wdata),
        .dec   (dec),
        .wr    (wr_req)
    );

    bankemu_regs #(.RESET_BANK(RESET_BANK)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr_req),
        .exec_bank (exec_bank),
        .ind_bank  (ind_bank)
    );

    bankemu_mux #(.FORCE_BANK(FORCE_BANK)) u_mux (
        .dec            (dec),
        .phi2           (phi2),
        .rw             (rw),
        .indirect_cycle (indirect_cycle),
        .exec_bank      (exec_bank),
        .ind_bank       (ind_bank),
        .bank           (bank),
        .rdata          (rdata),
        .rdata_oe       (rdata_oe)
    );

endmodule

// File: rtl/bankemu_chk.sv
module bankemu_chk
    import bankemu_pkg::*;
#(
    parameter logic [3:0] FORCE_BANK = 4'hE,
    parameter logic [3:0] RESET_BANK = 4'hF
) (
    input logic        clk,
    input logic        rst,
    input logic        phi2,
    input logic        rw,
    input logic [15:0] addr,
    input logic [3:0]  bank,
    input logic [7:0]  rdata,
    input logic        rdata_oe,
    input wr_req_t     wr,
    input bank_t       exec_bank,
    input bank_t       ind_bank
);

    // R1
    reset_value_chk: assert property (@(posedge clk)
        $fell(rst) |-> (exec_bank == RESET_BANK && ind_bank == RESET_BANK));

    // R2
    forced_bank_chk: assert property (@(posedge clk) disable iff (rst)
        (addr[15:1] == 15'd0) |-> (bank == FORCE_BANK));

    // R6
    oe_window_chk: assert property (@(posedge clk) disable iff (rst)
        rdata_oe |-> (phi2 && rw && addr[15:1] == 15'd0));

    // R6
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rdata_oe |-> (rdata[7:4] == 4'h0));

    // R5
    exec_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr.valid && wr.sel == SEL_EXEC) |=> (exec_bank == $past(wr.nib)));

    // R7
    exec_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr.valid && wr.sel == SEL_EXEC) |=> $stable(exec_bank));

    // R7
    ind_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr.valid && wr.sel == SEL_IND) |=> $stable(ind_bank));

endmodule

bind bankemu bankemu_chk #(.FORCE_BANK(FORCE_BANK), .RESET_BANK(RESET_BANK)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .phi2      (phi2),
    .rw        (rw),
    .addr      (addr),
    .bank      (bank),
    .rdata     (rdata),
    .rdata_oe  (rdata_oe),
    .wr        (wr_req),
    .exec_bank (exec_bank),
    .ind_bank  (ind_bank)
);

// File: tb/bankemu_bench.sv
`timescale 1ns/1ps
module bankemu_bench;

    localparam logic [3:0] FORCE = 4'hE;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        phi2 = 1'b0;
    logic        rw = 1'b1;
    logic [15:0] addr = 16'h1234;
    logic [7:0]  wdata = 8'h00;
    logic        indirect_cycle = 1'b0;
    logic [3:0]  bank;
    logic [7:0]  rdata;
    logic        rdata_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference model state
    logic [3:0]  m_exec = 4'hF;
    logic [3:0]  m_ind  = 4'hF;
    logic        m_phi2_q = 1'b0;
    logic        m_rw_q = 1'b1;
    logic [15:0] m_addr_q = 16'h0;
    logic [7:0]  m_data_q = 8'h0;

    always #4 clk = ~clk;

    bankemu u_bankemu (
        .clk            (clk),
        .rst            (rst),
        .phi2           (phi2),
        .rw             (rw),
        .addr           (addr),
        .wdata          (wdata),
        .indirect_cycle (indirect_cycle),
        .bank           (bank),
        .rdata          (rdata),
        .rdata_oe       (rdata_oe)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_exec   = 4'hF;
            m_ind    = 4'hF;
            m_phi2_q = 1'b0;
            m_rw_q   = 1'b1;
            m_addr_q = 16'h0;
            m_data_q = 8'h0;
        end else begin
            if (m_phi2_q && !phi2 && !m_rw_q && m_addr_q < 16'd2) begin
                if (m_addr_q[0]) m_ind = m_data_q[3:0];
                else             m_exec = m_data_q[3:0];
            end
            m_phi2_q = phi2;
            m_rw_q   = rw;
            m_addr_q = addr;
            m_data_q = wdata;
        end
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic p, input logic r, input logic [15:0] a,
                        input logic [7:0] d, input logic ind, input string tag);
        logic [3:0] eb;
        logic       eo;
        @(negedge clk);
        phi2 = p; rw = r; addr = a; wdata = d; indirect_cycle = ind;
        #1;
        eb = (a < 16'd2) ? FORCE : (ind ? m_ind : m_exec);
        eo = p && r && (a < 16'd2);
        check(tag, "bank", int'(bank), int'(eb));
        check(tag, "rdata_oe", int'(rdata_oe), int'(eo));
        if (eo) check(tag, "rdata", int'(rdata), int'({4'h0, a[0] ? m_ind : m_exec}));
    endtask

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d, input string tag);
        step(1'b1, 1'b0, a, d, 1'b0, tag);
        step(1'b0, 1'b0, a, d, 1'b0, tag);
    endtask

    task automatic cpu_read(input logic [15:0] a, input logic ind, input string tag);
        step(1'b1, 1'b1, a, 8'h00, ind, tag);
        step(1'b0, 1'b1, a, 8'h00, ind, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset value on normal and indirect cycles
        step(1'b1, 1'b1, 16'h1234, 8'h00, 1'b0, "R1");
        check("R1", "bank_exec_reset", int'(bank), 15);
        step(1'b1, 1'b1, 16'h1234, 8'h00, 1'b1, "R1");
        check("R1", "bank_ind_reset", int'(bank), 15);
        // R5: write with upper nibble set, only low nibble kept
        cpu_write(16'h0000, 8'hA7, "R5");
        step(1'b1, 1'b1, 16'h2000, 8'h00, 1'b0, "R3");
        check("R5", "exec_after_write", int'(bank), 7);
        cpu_write(16'h0001, 8'hF5, "R5");
        // R3 / R4
        step(1'b1, 1'b1, 16'h3000, 8'h00, 1'b1, "R4");
        check("R4", "ind_bank", int'(bank), 5);
        step(1'b1, 1'b1, 16'hFFFF, 8'h00, 1'b0, "R3");
        check("R3", "exec_bank", int'(bank), 7);
        // R6: read both registers, upper bits zero
        cpu_read(16'h0000, 1'b0, "R6");
        cpu_read(16'h0001, 1'b0, "R6");
        step(1'b1, 1'b1, 16'h0001, 8'h00, 1'b0, "R6");
        check("R6", "rdata_ind", int'(rdata), 8'h05);
        // R2: indirect cycle at a register address still forced
        step(1'b1, 1'b1, 16'h0001, 8'h00, 1'b1, "R2");
        check("R2", "forced_with_ind", int'(bank), int'(FORCE));
        step(1'b0, 1'b0, 16'h0000, 8'h33, 1'b1, "R2");
        // R9 / R7: aliases not decoded, writes elsewhere ignored
        cpu_write(16'h0100, 8'h02, "R9");
        cpu_write(16'h8001, 8'h03, "R9");
        cpu_read(16'h0100, 1'b0, "R9");
        step(1'b1, 1'b1, 16'h4000, 8'h00, 1'b0, "R7");
        check("R7", "exec_unchanged", int'(bank), 7);
        step(1'b1, 1'b1, 16'h4000, 8'h00, 1'b1, "R7");
        check("R7", "ind_unchanged", int'(bank), 5);
        // R8: read across a phi2 fall leaves registers alone
        cpu_read(16'h0000, 1'b0, "R8");
        cpu_read(16'h0001, 1'b0, "R8");
        step(1'b1, 1'b1, 16'h5000, 8'h00, 1'b0, "R8");
        check("R8", "exec_after_read", int'(bank), 7);
        // R5: indirect register takes a new value, then execution register
        cpu_write(16'h0001, 8'h0C, "R5");
        step(1'b1, 1'b1, 16'h6000, 8'h00, 1'b1, "R4");
        check("R4", "ind_new", int'(bank), 12);
        cpu_write(16'h0000, 8'h10, "R5");
        step(1'b1, 1'b1, 16'h6000, 8'h00, 1'b0, "R3");
        check("R3", "exec_zero", int'(bank), 0);
        // R6: phi2 low read gives no enable
        step(1'b0, 1'b1, 16'h0000, 8'h00, 1'b0, "R6");
        check("R6", "oe_phi2_low", int'(rdata_oe), 0);
        step(1'b1, 1'b1, 16'h0000, 8'h00, 1'b0, "R6");
        check("R6", "rdata_exec", int'(rdata), 0);
        step(1'b1, 1'b1, 16'h7000, 8'h00, 1'b0, "R3");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule